// File: doc/BRIEF.md
# CAN Receive Bit Destuffer (Classic / FD / XL)

This block sits on the sampled bit stream of a CAN receiver, downstream of bit-timing recovery. It takes one sampled bus bit per strobe and removes the stuff bits. What is left is the true frame bits, each tagged with its frame index. SOF carries index 0, and the index never counts stuff bits.

Classic frames use dynamic stuffing from start to end. FD frames switch to fixed stuffing, with one stuff bit every four frame bits, starting at an index supplied by the frame decoder. XL frames switch to fixed stuffing with one stuff bit every ten frame bits, starting after the low bit at index 20. Above a second supplied index, which is the last CRC bit, nothing is treated as a stuff bit. This covers the CRC delimiter, the ACK field and the end-of-frame bits.

The block checks the polarity of every stuff bit. It keeps a modulo-8 count of removed dynamic stuff bits, which a downstream checker compares against the transmitted stuff count. The frame decoder pulses `frame_start` when it detects the start of a frame, and it drives the mode and index inputs as it decodes the header.

Top module: `can_unstuffer`

## Requirements
- R1: After reset, `dout_vld`, `dout_bit`, `dout_idx`, `stuff_vld`, `stuff_err` and `dyn_cnt` are 0, and the block is idle. While idle, a strobed bit produces no output pulse.
- R2: A `frame_start` pulse makes the block active, clears `dyn_cnt` to 0, and makes the next accepted frame bit index 0. A `bit_stb` in the same cycle as `frame_start` is ignored.
- R3: In a dynamic-stuffing position, a bit is removed as a stuff bit if it follows five equal raw bits and has the opposite value. The count of equal bits includes earlier stuff bits. A removed bit gives a `stuff_vld` pulse and no `dout_vld`.
- R4: In a dynamic-stuffing position, a sixth equal bit does three things. It pulses `stuff_err` with neither `stuff_vld` nor `dout_vld`, it resets the run count, and it returns the block to idle until the next `frame_start`.
- R5: With `mode_fd`=1 and `mode_xl`=0, every candidate position n ≥ `fd_fix_idx` is a fixed-stuffing position. A raw bit is removed there whenever (n − `fd_fix_idx`) mod 4 = 0, whatever the preceding run lengths. No dynamic stuff bit is removed in that region.
- R6: With `mode_xl`=1, dynamic stuffing applies up to position n = 20. For n > 20, a fixed stuff bit is removed before frame bits 30, 40, 50 and so on, and no dynamic stuff bit is removed.
- R7: A fixed stuff bit must be the complement of the raw bit before it. If it is not, `stuff_err` pulses together with `stuff_vld`, the bit is still removed, and decoding continues with the same frame index.
- R8: The raw bit that follows a removed stuff bit is always a frame bit. Two stuff positions that coincide therefore remove only one bit.
- R9: No bit is removed at candidate positions n > `stuff_end_idx`, whatever the run lengths.
- R10: `dyn_cnt` equals the number of dynamic stuff bits removed since `frame_start`, modulo 8. Fixed stuff bits do not change it.
- R11: Each frame bit appears exactly one clock after its strobe, as a `dout_vld` pulse. `dout_bit` holds the bit value and `dout_idx` holds its index, which starts at 0 and rises by one for each frame bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame pulse; arms the block and clears index and count |
| bit_stb | input | 1 | One sampled bus bit is present on `bit_in` |
| bit_in | input | 1 | Sampled bus bit |
| mode_fd | input | 1 | Frame uses FD framing |
| mode_xl | input | 1 | Frame uses XL framing (overrides `mode_fd`) |
| fd_fix_idx | input | IDX_W | FD: first frame index preceded by a fixed stuff bit |
| stuff_end_idx | input | IDX_W | Index of the last CRC bit; no stuffing beyond it |
| dout_vld | output | 1 | A frame bit is presented |
| dout_bit | output | 1 | Frame bit value |
| dout_idx | output | IDX_W | Frame index of `dout_bit` |
| stuff_vld | output | 1 | A stuff bit was removed |
| stuff_err | output | 1 | Stuff rule violated |
| dyn_cnt | output | CNT_W | Removed dynamic stuff bits, modulo 2^CNT_W |

## Verification
A wrong run length, phase or index inside this block shows up at the ports at the first strobe where the faulty state decides something. One of three things happens there: a frame bit is swallowed as stuff, a stuff bit leaks out as `dout_vld`, or a false `stuff_err` appears. From then on, every later `dout_idx` is shifted, so each later frame bit reports the fault on the clock after its strobe. A wrong stuff count stays hidden until `dyn_cnt` is read at the end of the frame. The sweeps therefore compare every output pulse with an encoder in the bench, and they compare `dyn_cnt` after every frame.

// File: rtl/can_unstuff_pkg.sv
package can_unstuff_pkg;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACTIVE = 1'b1
   } unstuff_state_e;

   // width needed to hold the value v
   function automatic int width_for(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/unstuff_runlen.sv
module unstuff_runlen
   import can_unstuff_pkg::*;
#(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   input  logic bit_in,
   output logic run_full,
   output logic last_bit
);

   localparam int              RL_W   = width_for(RUN_LEN);
   localparam logic [RL_W-1:0] RL_MAX = RL_W'(RUN_LEN);

   logic [RL_W-1:0] run_q;
   logic            last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         last_q <= 1'b0;
      end else if (clr) begin
         run_q  <= '0;
         last_q <= 1'b0;
      end else if (adv) begin
         if ((run_q != '0) && (bit_in == last_q)) begin
            if (run_q != RL_MAX) run_q <= run_q + RL_W'(1);
         end else begin
            run_q <= RL_W'(1);
         end
         last_q <= bit_in;
      end
   end

   assign run_full = (run_q == RL_MAX);
   assign last_bit = last_q;

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) run_q <= RL_MAX); // R3
   AST_RUN_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n) (adv && !clr) |=> (run_q != '0)); // R3

endmodule

// File: rtl/unstuff_fixgrid.sv
module unstuff_fixgrid
   import can_unstuff_pkg::*;
#(
   parameter int IDX_W  = 15,
   parameter int PERIOD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [IDX_W-1:0] n_cur,
   input  logic [IDX_W-1:0] origin,
   output logic             due
);

   localparam int              PH_W    = width_for(PERIOD - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_inc;
   logic            past_origin;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("unstuff_fixgrid: PERIOD must be at least 2");
      end
      if (is_pow2(PERIOD)) begin : g_wrap
         // power-of-two period: the phase counter wraps on its own
         assign ph_inc = ph_q + PH_W'(1);
      end else begin : g_mod
         assign ph_inc = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
         AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ph_q <= PH_LAST); // R6
      end
   endgenerate

   assign past_origin = (n_cur >= origin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (clr) begin
         ph_q <= '0;
      end else if (adv) begin
         if ((n_cur + IDX_W'(1)) == origin) ph_q <= '0;
         else if (past_origin)              ph_q <= ph_inc;
      end
   end

   assign due = past_origin && (ph_q == '0);

endmodule

// File: rtl/unstuff_modcnt.sv
module unstuff_modcnt #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (inc)  count <= count + CNT_W'(1);
   end

endmodule

// File: rtl/can_unstuffer.sv
module can_unstuffer
   import can_unstuff_pkg::*;
#(
   parameter int IDX_W      = 15,
   parameter int RUN_LEN    = 5,
   parameter int FD_PERIOD  = 4,
   parameter int XL_PERIOD  = 10,
   parameter int XL_DL1_IDX = 20,
   parameter int CNT_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             bit_stb,
   input  logic             bit_in,
   input  logic             mode_fd,
   input  logic             mode_xl,
   input  logic [IDX_W-1:0] fd_fix_idx,
   input  logic [IDX_W-1:0] stuff_end_idx,
   output logic             dout_vld,
   output logic             dout_bit,
   output logic [IDX_W-1:0] dout_idx,
   output logic             stuff_vld,
   output logic             stuff_err,
   output logic [CNT_W-1:0] dyn_cnt
);

   localparam logic [IDX_W-1:0] XL_LAST_DYN = IDX_W'(XL_DL1_IDX);
   localparam logic [IDX_W-1:0] XL_ORIGIN   = IDX_W'(XL_DL1_IDX + XL_PERIOD);
   localparam logic [IDX_W-1:0] IDX_MAX     = '1;

   generate
      if (IDX_W < 8) begin : g_bad_idx_w
         $error("can_unstuffer: IDX_W too small for a frame header");
      end
      if (XL_DL1_IDX + XL_PERIOD >= 2**IDX_W) begin : g_bad_xl_origin
         $error("can_unstuffer: XL stuffing origin does not fit IDX_W");
      end
      if (RUN_LEN < 1) begin : g_bad_run
         $error("can_unstuffer: RUN_LEN must be positive");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("can_unstuffer: CNT_W must be positive");
      end
   endgenerate

   unstuff_state_e   state_q;
   logic [IDX_W-1:0] n_q;
   logic             after_stuff_q;

   logic take, in_zone, xl_fixed, fd_fixed, fixed_zone;
   logic fd_due, xl_due, fixed_due;
   logic run_full, last_bit;
   logic is_fix_stuff, is_dyn_stuff, dyn_bad, fix_bad, is_data;

   // ---------------- position classification ----------------
   assign take       = (state_q == ST_ACTIVE) && bit_stb && !frame_start;
   assign in_zone    = !after_stuff_q && (n_q <= stuff_end_idx);
   assign xl_fixed   = mode_xl && (n_q > XL_LAST_DYN);
   assign fd_fixed   = mode_fd && !mode_xl && (n_q >= fd_fix_idx);
   assign fixed_zone = xl_fixed || fd_fixed;
   assign fixed_due  = mode_xl ? xl_due : fd_due;

   assign is_fix_stuff = take && in_zone && fixed_zone && fixed_due;
   assign is_dyn_stuff = take && in_zone && !fixed_zone && run_full;
   assign dyn_bad      = is_dyn_stuff && (bit_in == last_bit);
   assign fix_bad      = is_fix_stuff && (bit_in == last_bit);
   assign is_data      = take && !is_fix_stuff && !is_dyn_stuff;

   // ---------------- sub-blocks ----------------
   unstuff_runlen #(.RUN_LEN(RUN_LEN)) run_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (frame_start || dyn_bad),
      .adv      (take && !dyn_bad),
      .bit_in   (bit_in),
      .run_full (run_full),
      .last_bit (last_bit)
   );

   unstuff_fixgrid #(.IDX_W(IDX_W), .PERIOD(FD_PERIOD)) fd_grid_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (frame_start),
      .adv    (is_data),
      .n_cur  (n_q),
      .origin (fd_fix_idx),
      .due    (fd_due)
   );

   unstuff_fixgrid #(.IDX_W(IDX_W), .PERIOD(XL_PERIOD)) xl_grid_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (frame_start),
      .adv    (is_data),
      .n_cur  (n_q),
      .origin (XL_ORIGIN),
      .due    (xl_due)
   );

   unstuff_modcnt #(.CNT_W(CNT_W)) sbc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_start),
      .inc   (is_dyn_stuff && !dyn_bad),
      .count (dyn_cnt)
   );

   // ---------------- frame state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         n_q           <= '0;
         after_stuff_q <= 1'b0;
      end else if (frame_start) begin
         state_q       <= ST_ACTIVE;
         n_q           <= '0;
         after_stuff_q <= 1'b0;
      end else begin
         if (dyn_bad)  state_q <= ST_IDLE;
         if (is_data)  n_q     <= n_q + IDX_W'(1);
         if (take)     after_stuff_q <= (is_fix_stuff || is_dyn_stuff) && !dyn_bad;
      end
   end

   // ---------------- registered outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_vld  <= 1'b0;
         dout_bit  <= 1'b0;
         dout_idx  <= '0;
         stuff_vld <= 1'b0;
         stuff_err <= 1'b0;
      end else begin
         dout_vld  <= is_data;
         stuff_vld <= (is_fix_stuff || is_dyn_stuff) && !dyn_bad;
         stuff_err <= dyn_bad || fix_bad;
         if (is_data) begin
            dout_bit <= bit_in;
            dout_idx <= n_q;
         end
      end
   end

   // ---------------- observation registers for properties ----------------
   logic             chk_prev_stuff_q;
   logic             chk_have_idx_q;
   logic [IDX_W-1:0] chk_last_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_prev_stuff_q <= 1'b0;
         chk_have_idx_q   <= 1'b0;
         chk_last_idx_q   <= '0;
      end else if (frame_start) begin
         chk_prev_stuff_q <= 1'b0;
         chk_have_idx_q   <= 1'b0;
      end else begin
         if (stuff_vld)     chk_prev_stuff_q <= 1'b1;
         else if (dout_vld) chk_prev_stuff_q <= 1'b0;
         if (dout_vld) begin
            chk_have_idx_q <= 1'b1;
            chk_last_idx_q <= dout_idx;
         end
      end
   end

   AST_SINGLE_STUFF: assert property (@(posedge clk) disable iff (!rst_n) stuff_vld |-> !chk_prev_stuff_q); // R8
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (dout_vld && chk_have_idx_q) |-> (dout_idx == chk_last_idx_q + IDX_W'(1))); // R11
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) is_data |-> (n_q != IDX_MAX)); // R11
   AST_NO_STUFF_PAST_END: assert property (@(posedge clk) disable iff (!rst_n) stuff_vld |-> (n_q <= stuff_end_idx)); // R9
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) ((dyn_cnt != $past(dyn_cnt)) && !$past(frame_start)) |-> (stuff_vld && (dyn_cnt == $past(dyn_cnt) + CNT_W'(1)))); // R10
   AST_QUIET_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n) (stuff_err && !stuff_vld) |=> (!dout_vld && !stuff_vld)); // R4
   AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dout_vld && stuff_vld)); // R3

endmodule

// File: tb/can_unstuffer_tb.sv
module can_unstuffer_tb_top;

   localparam int IW    = 15;
   localparam int XL_D  = 20;
   localparam int XL_P  = 10;
   localparam int FD_P  = 4;
   localparam int RUNL  = 5;
   localparam int MAXR  = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          bit_stb = 1'b0;
   logic          bit_in = 1'b0;
   logic          mode_fd = 1'b0;
   logic          mode_xl = 1'b0;
   logic [IW-1:0] fd_fix_idx = '0;
   logic [IW-1:0] stuff_end_idx = '0;
   logic          dout_vld, dout_bit, stuff_vld, stuff_err;
   logic [IW-1:0] dout_idx;
   logic [2:0]    dyn_cnt;

   can_unstuffer #(.IDX_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_stb(bit_stb),
      .bit_in(bit_in), .mode_fd(mode_fd), .mode_xl(mode_xl),
      .fd_fix_idx(fd_fix_idx), .stuff_end_idx(stuff_end_idx),
      .dout_vld(dout_vld), .dout_bit(dout_bit), .dout_idx(dout_idx),
      .stuff_vld(stuff_vld), .stuff_err(stuff_err), .dyn_cnt(dyn_cnt)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   bit   dbits [0:255];
   bit   rbit  [0:MAXR-1];
   bit   rstf  [0:MAXR-1];
   int   ridx  [0:MAXR-1];
   int   rkind [0:MAXR-1];
   int   rlen;
   int   exp_dyn;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string kind_tag(input int k);
      case (k)
         3: return "R3";
         5: return "R5";
         6: return "R6";
         8: return "R8";
         9: return "R9";
         default: return "R11";
      endcase
   endfunction

   // bench-side encoder: inserts stuff bits into dbits according to the rules
   task automatic build(input int len, input bit fd, input bit xl, input int fix, input int endi);
      int  run = 0;
      bit  last = 1'b0;
      bit  prev_stuff;
      rlen = 0;
      exp_dyn = 0;
      for (int i = 0; i < len; i++) begin
         bit fz, due;
         fz  = xl ? (i > XL_D) : (fd && (i >= fix));
         due = xl ? (((i - XL_D) % XL_P) == 0) : (((i - fix) % FD_P) == 0);
         prev_stuff = 1'b0;
         if ((i <= endi) && (fz ? due : (run >= RUNL))) begin
            rbit[rlen]  = ~last;
            rstf[rlen]  = 1'b1;
            ridx[rlen]  = i;
            rkind[rlen] = fz ? (xl ? 6 : 5) : 3;
            if (!fz) exp_dyn++;
            run  = 1;
            last = ~last;
            rlen++;
            prev_stuff = 1'b1;
         end
         rbit[rlen]  = dbits[i];
         rstf[rlen]  = 1'b0;
         ridx[rlen]  = i;
         rkind[rlen] = prev_stuff ? 8 : ((i > endi) ? 9 : 11);
         if (run > 0 && dbits[i] == last) run++;
         else run = 1;
         last = dbits[i];
         rlen++;
      end
   endtask

   function automatic bit pat_bit(input int p, input int i);
      case (p)
         0: return 1'b0;
         1: return 1'b1;
         2: return i[0];
         default: begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            return lfsr[0];
         end
      endcase
   endfunction

   // precondition: called just after a falling edge
   task automatic send(input bit b);
      bit_in  = b;
      bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
   endtask

   task automatic pulse_start();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic run_frame(input bit fd, input bit xl, input int fix, input int endi,
                            input int len, input int p);
      for (int i = 0; i < len; i++) dbits[i] = (i > endi) ? 1'b1 : pat_bit(p, i);
      build(len, fd, xl, fix, endi);
      mode_fd       = fd;
      mode_xl       = xl;
      fd_fix_idx    = IW'(fix);
      stuff_end_idx = IW'(endi);
      pulse_start();
      for (int j = 0; j < rlen; j++) begin
         send(rbit[j]);
         if (rstf[j]) begin
            chk(stuff_vld && !dout_vld && !stuff_err, kind_tag(rkind[j]),
                {stuff_vld, dout_vld, stuff_err}, 3'b100);
         end else begin
            chk(dout_vld && !stuff_vld && !stuff_err && (dout_bit == rbit[j]), kind_tag(rkind[j]),
                {dout_vld, stuff_vld, stuff_err, dout_bit}, {3'b100, rbit[j]});
            chk(dout_idx == IW'(ridx[j]), "R11", int'(dout_idx), ridx[j]);
         end
      end
      chk(dyn_cnt == 3'(exp_dyn), "R10", int'(dyn_cnt), exp_dyn % 8);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset values
      chk({dout_vld, dout_bit, stuff_vld, stuff_err} == 4'b0 && dout_idx == '0 && dyn_cnt == '0,
          "R1", {dout_vld, dout_bit, stuff_vld, stuff_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle ignores bits
      for (int k = 0; k < 4; k++) begin
         send(k[0]);
         chk(!dout_vld && !stuff_vld && !stuff_err, "R1", {dout_vld, stuff_vld, stuff_err}, 0);
      end

      // classic sweeps (R3, R9, R10, R11)
      for (int p = 0; p < 4; p++) run_frame(1'b0, 1'b0, 0, 34, 44, p);

      // R2: strobe together with frame_start is dropped, count cleared
      frame_start = 1'b1;
      bit_in      = 1'b1;
      bit_stb     = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      bit_stb     = 1'b0;
      chk(!dout_vld && !stuff_vld, "R2", {dout_vld, stuff_vld}, 0);
      chk(dyn_cnt == '0, "R2", int'(dyn_cnt), 0);
      send(1'b0);
      chk(dout_vld && dout_idx == '0 && dout_bit == 1'b0, "R2", int'(dout_idx), 0);

      // FD sweep over the fixed-stuffing origin (R5, R8)
      for (int f = 12; f < 20; f++) run_frame(1'b1, 1'b0, f, 40, 48, f % 4);

      // XL frames (R6, R8)
      run_frame(1'b0, 1'b1, 0, 90, 100, 0);
      run_frame(1'b0, 1'b1, 0, 90, 100, 3);
      run_frame(1'b1, 1'b1, 5, 90, 100, 2);

      // R4: sixth equal bit in dynamic mode
      mode_fd = 1'b0;
      mode_xl = 1'b0;
      stuff_end_idx = IW'(40);
      pulse_start();
      for (int k = 0; k < 5; k++) send(1'b0);
      send(1'b0);
      chk(stuff_err && !stuff_vld && !dout_vld, "R4", {stuff_err, stuff_vld, dout_vld}, 3'b100);
      for (int k = 0; k < 3; k++) begin
         send(k[0]);
         chk(!dout_vld && !stuff_vld && !stuff_err, "R4", {dout_vld, stuff_vld, stuff_err}, 0);
      end

      // R7: fixed stuff bit with the wrong polarity
      mode_fd = 1'b1;
      fd_fix_idx = IW'(8);
      stuff_end_idx = IW'(30);
      pulse_start();
      for (int k = 0; k < 8; k++) send(k[0]);
      send(1'b1);
      chk(stuff_err && stuff_vld && !dout_vld, "R7", {stuff_err, stuff_vld, dout_vld}, 3'b110);
      send(1'b0);
      chk(dout_vld && !stuff_err && dout_idx == IW'(8), "R7", int'(dout_idx), 8);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule